// File: doc/BRIEF.md
# Bus-Structured Register Datapath

This block is the execution datapath of a microcoded stack-oriented integer engine. Every clock cycle it takes one decoded control word and carries out a single transfer. A 4-bit code puts one register onto the B bus. The ALU combines that bus with a dedicated holding register, and the ALU result passes through a shifter onto the C bus. A 9-bit mask then chooses which registers capture the C bus at the clock edge. Any number of registers, or none, can be chosen.

The sequencer and the control store sit outside this block. The sequencer drives the control word and reads back the negative and zero flags in the following cycle. The memory side works through three registers that appear as outputs: the address register, the data register and the code pointer. Words returned from memory load the data register, and fetched code bytes load a separate byte register. The byte register reaches the B bus either sign-extended or zero-extended.

Top module: `bus_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, all nine C-writable registers, the byte register and both flags clear to zero.
- R2: `b_sel` selects the B bus source as follows: 0 data register, 1 code pointer, 2 byte register, 3 stack pointer, 4 frame base, 5 pool base, 6 stack top, 7 scratch, 8 address register. Codes 9 to 15 drive zero onto the bus.
- R3: With code 2 selected, the byte register is sign-extended when `b_byte_sext` is 1 and zero-extended when it is 0. The byte register loads `byte_in` at an edge where `byte_we` is high.
- R4: `alu_ctl` bits are: 7 shift left by 8, 6 arithmetic shift right by 1, 5:4 function, 3 left enable, 2 right enable, 1 invert left, 0 carry-in. The left term is the holding register, or zero when bit 3 is low, and it is inverted when bit 1 is set. The right term is the B bus, or zero when bit 2 is low. Function 0 is AND, 1 is OR, 2 is NOT of the right term, and 3 is left + right + carry-in, taken modulo 2^32.
- R5: The shifter first shifts the ALU result left by 8 when bit 7 is set, and then shifts it arithmetically right by 1 when bit 6 is set. The C bus is the shifter output.
- R6: At every edge out of reset, `flag_n` loads bit 31 of the unshifted ALU result and `flag_z` loads whether that result is zero. Both are visible in the next cycle.
- R7: `c_mask` bit k writes register k: 0 holding, 1 address, 2 data, 3 code pointer, 4 stack pointer, 5 frame base, 6 pool base, 7 stack top, 8 scratch. All selected registers capture the same C value at one edge, and unselected registers keep their value.
- R8: A register that is the B source and a C destination in the same cycle computes with its old value and holds the new value after the edge.
- R9: The left ALU operand always comes from the holding register. Function OR with only the right operand enabled passes B through, so the holding register can be loaded from any B source.
- R10: With `mem_we` high and `c_mask` bit 2 low, the data register loads `mem_rdata` at the edge.
- R11: When `mem_we` is high and `c_mask` bit 2 is set in the same cycle, the data register takes the C bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| b_sel | input | 4 | Selects the B bus source |
| b_byte_sext | input | 1 | Sign-extends the byte source (1) or zero-extends it (0) |
| alu_ctl | input | 8 | ALU and shifter control field |
| c_mask | input | 9 | C bus write enables, one per register |
| mem_we | input | 1 | Loads a memory word into the data register |
| mem_rdata | input | 32 | Word returned from memory |
| byte_we | input | 1 | Loads a fetched code byte |
| byte_in | input | 8 | Fetched code byte |
| addr_out | output | 32 | Address register |
| data_out | output | 32 | Data register |
| pc_out | output | 32 | Code pointer register |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
Two events can land on the same edge. A register can be both the B source and a C destination, and a memory word can arrive for the data register in the cycle the C bus also writes it. The bench provokes the first case by incrementing the stack pointer and the code pointer onto themselves. It provokes the second by raising `mem_we` with a distinct word while the mask selects the data register. An arithmetic model in the bench, updated edge by edge, judges each result, and read-back transfers through the address register expose every register that has no port of its own.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // C-bus destination indices (also the c_mask bit positions)
  localparam int unsigned RI_HOLD  = 0;
  localparam int unsigned RI_ADDR  = 1;
  localparam int unsigned RI_DATA  = 2;
  localparam int unsigned RI_PC    = 3;
  localparam int unsigned RI_SP    = 4;
  localparam int unsigned RI_FRAME = 5;
  localparam int unsigned RI_POOL  = 6;
  localparam int unsigned RI_TOP   = 7;
  localparam int unsigned RI_SCR   = 8;
  localparam int unsigned NUM_DST  = 9;

  // B-bus source codes
  localparam logic [3:0] BS_DATA  = 4'd0;
  localparam logic [3:0] BS_PC    = 4'd1;
  localparam logic [3:0] BS_BYTE  = 4'd2;
  localparam logic [3:0] BS_SP    = 4'd3;
  localparam logic [3:0] BS_FRAME = 4'd4;
  localparam logic [3:0] BS_POOL  = 4'd5;
  localparam logic [3:0] BS_TOP   = 4'd6;
  localparam logic [3:0] BS_SCR   = 4'd7;
  localparam logic [3:0] BS_ADDR  = 4'd8;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_NOTB = 2'd2,
    FN_ADD = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic    shl;
    logic    sra;
    alu_fn_e fn;
    logic    ena;
    logic    enb;
    logic    inva;
    logic    cin;
  } alu_ctl_t;
endpackage

// File: rtl/dp_bsel.sv
module dp_bsel
  import dp_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned BW   = 8,
  parameter int unsigned NDST = 9
) (
  input  logic [NDST-1:0][W-1:0] rf_q,
  input  logic [BW-1:0]          byte_q,
  input  logic [3:0]             sel,
  input  logic                   sext,
  output logic [W-1:0]           b_bus
);
  localparam int unsigned EXT = W - BW;

  logic [W-1:0] byte_ext;
  assign byte_ext = {{EXT{byte_q[BW-1] & sext}}, byte_q};

  always_comb begin
    unique case (sel)
      BS_DATA:  b_bus = rf_q[RI_DATA];
      BS_PC:    b_bus = rf_q[RI_PC];
      BS_BYTE:  b_bus = byte_ext;
      BS_SP:    b_bus = rf_q[RI_SP];
      BS_FRAME: b_bus = rf_q[RI_FRAME];
      BS_POOL:  b_bus = rf_q[RI_POOL];
      BS_TOP:   b_bus = rf_q[RI_TOP];
      BS_SCR:   b_bus = rf_q[RI_SCR];
      BS_ADDR:  b_bus = rf_q[RI_ADDR];
      default:  b_bus = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned SHL = 8
) (
  input  alu_ctl_t     ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] alu_raw,
  output logic [W-1:0] shift_out
);
  logic [W-1:0] a_t, b_t, s_l;

  always_comb begin
    a_t = ctl.ena ? a_in : '0;
    if (ctl.inva) a_t = ~a_t;
    b_t = ctl.enb ? b_in : '0;
    unique case (ctl.fn)
      FN_AND:  alu_raw = a_t & b_t;
      FN_OR:   alu_raw = a_t | b_t;
      FN_NOTB: alu_raw = ~b_t;
      default: alu_raw = a_t + b_t + {{(W-1){1'b0}}, ctl.cin};
    endcase
  end

  always_comb begin
    s_l = ctl.shl ? (alu_raw << SHL) : alu_raw;
    shift_out = ctl.sra ? W'($signed(s_l) >>> 1) : s_l;
  end
endmodule

// File: rtl/dp_regs.sv
module dp_regs
  import dp_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned BW   = 8,
  parameter int unsigned NDST = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [W-1:0]           c_bus,
  input  logic [NDST-1:0]        c_mask,
  input  logic                   mem_we,
  input  logic [W-1:0]           mem_rdata,
  input  logic                   byte_we,
  input  logic [BW-1:0]          byte_in,
  output logic [NDST-1:0][W-1:0] rf_q,
  output logic [BW-1:0]          byte_q
);
  for (genvar g = 0; g < NDST; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (c_mask[g])
        q <= c_bus;
      else if ((g == RI_DATA) && mem_we)
        q <= mem_rdata;
    end
    assign rf_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      byte_q <= '0;
    else if (byte_we)
      byte_q <= byte_in;
  end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import dp_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned BW  = 8,
  parameter int unsigned SHL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    b_sel,
  input  logic          b_byte_sext,
  input  logic [7:0]    alu_ctl,
  input  logic [8:0]    c_mask,
  input  logic          mem_we,
  input  logic [W-1:0]  mem_rdata,
  input  logic          byte_we,
  input  logic [BW-1:0] byte_in,
  output logic [W-1:0]  addr_out,
  output logic [W-1:0]  data_out,
  output logic [W-1:0]  pc_out,
  output logic          flag_n,
  output logic          flag_z
);
  localparam int unsigned NDST = NUM_DST;

  logic [NDST-1:0][W-1:0] rf_q;
  logic [BW-1:0]          byte_q;
  logic [W-1:0]           b_bus, alu_raw, c_bus;
  alu_ctl_t               ctl;

  assign ctl = alu_ctl_t'(alu_ctl);

  dp_bsel #(.W(W), .BW(BW), .NDST(NDST)) u_bsel (
    .rf_q(rf_q), .byte_q(byte_q), .sel(b_sel), .sext(b_byte_sext), .b_bus(b_bus)
  );

  dp_alu #(.W(W), .SHL(SHL)) u_alu (
    .ctl(ctl), .a_in(rf_q[RI_HOLD]), .b_in(b_bus),
    .alu_raw(alu_raw), .shift_out(c_bus)
  );

  dp_regs #(.W(W), .BW(BW), .NDST(NDST)) u_regs (
    .clk(clk), .rst(rst), .c_bus(c_bus), .c_mask(c_mask),
    .mem_we(mem_we), .mem_rdata(mem_rdata),
    .byte_we(byte_we), .byte_in(byte_in),
    .rf_q(rf_q), .byte_q(byte_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      flag_n <= alu_raw[W-1];
      flag_z <= (alu_raw == '0);
    end
  end

  assign addr_out = rf_q[RI_ADDR];
  assign data_out = rf_q[RI_DATA];
  assign pc_out   = rf_q[RI_PC];
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int unsigned W  = 32,
  parameter int unsigned BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    b_sel,
  input logic [8:0]    c_mask,
  input logic          mem_we,
  input logic [W-1:0]  mem_rdata,
  input logic          byte_we,
  input logic [BW-1:0] byte_in,
  input logic [BW-1:0] byte_q,
  input logic [W-1:0]  b_bus,
  input logic [W-1:0]  alu_raw,
  input logic [W-1:0]  c_bus,
  input logic [W-1:0]  data_out,
  input logic [W-1:0]  pc_out,
  input logic          flag_n,
  input logic          flag_z
);
  assert_unused_code_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (b_sel > 4'd8) |-> (b_bus == '0));

  assert_byte_load_R3: assert property (@(posedge clk) disable iff (rst)
    byte_we |=> (byte_q == $past(byte_in)));

  assert_flag_n_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_n == $past(alu_raw[W-1])));

  assert_flag_z_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_z == ($past(alu_raw) == '0)));

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !c_mask[3] |=> $stable(pc_out));

  assert_c_wins_R11: assert property (@(posedge clk) disable iff (rst)
    c_mask[2] |=> (data_out == $past(c_bus)));

  assert_mem_load_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !c_mask[2]) |=> (data_out == $past(mem_rdata)));
endmodule

bind bus_datapath dp_checker #(.W(W), .BW(BW)) i_chk (
  .clk(clk), .rst(rst), .b_sel(b_sel), .c_mask(c_mask),
  .mem_we(mem_we), .mem_rdata(mem_rdata), .byte_we(byte_we), .byte_in(byte_in),
  .byte_q(byte_q), .b_bus(b_bus), .alu_raw(alu_raw), .c_bus(c_bus),
  .data_out(data_out), .pc_out(pc_out), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/test_bus_datapath.sv
module test_bus_datapath;
  localparam logic [7:0] PASS_B = 8'h14;
  localparam logic [7:0] PASS_A = 8'h18;
  localparam logic [7:0] INC_B  = 8'h35;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  b_sel = '0;
  logic        b_byte_sext = 1'b0;
  logic [7:0]  alu_ctl = '0;
  logic [8:0]  c_mask = '0;
  logic        mem_we = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        byte_we = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [31:0] addr_out, data_out, pc_out;
  logic        flag_n, flag_z;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh [9];
  logic [7:0]  sbyte;
  logic        en, ez;

  always #10 clk = ~clk;

  bus_datapath i_bus_datapath (
    .clk(clk), .rst(rst), .b_sel(b_sel), .b_byte_sext(b_byte_sext),
    .alu_ctl(alu_ctl), .c_mask(c_mask), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .byte_we(byte_we), .byte_in(byte_in), .addr_out(addr_out),
    .data_out(data_out), .pc_out(pc_out), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] bsrc(input logic [3:0] c, input logic sx);
    case (c)
      4'd0: return sh[2];
      4'd1: return sh[3];
      4'd2: return sx ? {{24{sbyte[7]}}, sbyte} : {24'h0, sbyte};
      4'd3: return sh[4];
      4'd4: return sh[5];
      4'd5: return sh[6];
      4'd6: return sh[7];
      4'd7: return sh[8];
      4'd8: return sh[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic [3:0] bs, input logic sx, input logic [7:0] ac,
                      input logic [8:0] cm, input logic mwe, input logic [31:0] md,
                      input logic bwe, input logic [7:0] bd, input string tag);
    logic [31:0] a, b, y, s;
    b = ac[2] ? bsrc(bs, sx) : 32'h0;
    a = ac[3] ? sh[0] : 32'h0;
    if (ac[1]) a = ~a;
    case (ac[5:4])
      2'd0: y = a & b;
      2'd1: y = a | b;
      2'd2: y = ~b;
      default: y = a + b + {31'h0, ac[0]};
    endcase
    s = ac[7] ? (y << 8) : y;
    if (ac[6]) s = {s[31], s[31:1]};
    b_sel = bs; b_byte_sext = sx; alu_ctl = ac; c_mask = cm;
    mem_we = mwe; mem_rdata = md; byte_we = bwe; byte_in = bd;
    @(posedge clk);
    for (int k = 0; k < 9; k++) begin
      if (cm[k]) sh[k] = s;
      else if (k == 2 && mwe) sh[k] = md;
    end
    if (bwe) sbyte = bd;
    en = y[31];
    ez = (y == 32'h0);
    @(negedge clk);
    mem_we = 1'b0; byte_we = 1'b0; c_mask = '0;
    chk(tag, addr_out, sh[1]);
    chk(tag, data_out, sh[2]);
    chk(tag, pc_out, sh[3]);
    chk("R6", {31'h0, flag_n}, {31'h0, en});
    chk("R6", {31'h0, flag_z}, {31'h0, ez});
  endtask

  function automatic logic [3:0] code_of(input int idx);
    case (idx)
      1: return 4'd8;
      2: return 4'd0;
      3: return 4'd1;
      default: return 4'(idx - 1);
    endcase
  endfunction

  task automatic readreg(input int idx, input string tag);
    if (idx == 0) step(4'd0, 1'b0, PASS_A, 9'h002, 1'b0, 32'h0, 1'b0, 8'h0, tag);
    else step(code_of(idx), 1'b0, PASS_B, 9'h002, 1'b0, 32'h0, 1'b0, 8'h0, tag);
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    step(4'd0, 1'b0, 8'h00, 9'h000, 1'b1, v, 1'b0, 8'h0, "R10");
    step(4'd0, 1'b0, PASS_B, 9'(1 << idx), 1'b0, 32'h0, 1'b0, 8'h0, "R7");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] opa [4];
    logic [31:0] opb [4];
    for (int k = 0; k < 9; k++) sh[k] = 32'h0;
    sbyte = 8'h0;
    opa[0] = 32'h0000_0000; opb[0] = 32'h0000_0000;
    opa[1] = 32'h8000_0001; opb[1] = 32'h7FFF_FFFF;
    opa[2] = 32'h1234_5678; opb[2] = 32'hFFFF_FFFF;
    opa[3] = 32'hFFFF_FFFF; opb[3] = 32'h0000_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", addr_out, 32'h0);
    chk("R1", data_out, 32'h0);
    chk("R1", pc_out, 32'h0);
    chk("R1", {30'h0, flag_n, flag_z}, 32'h0);
    rst = 1'b0;
    for (int k = 0; k < 9; k++) readreg(k, "R1");

    // preload distinct values, byte register loaded too (R3)
    for (int k = 0; k < 9; k++) load(k, 32'h1111_1111 * (k + 1) + 32'h0F0F_0000);
    step(4'd0, 1'b0, 8'h00, 9'h0, 1'b0, 32'h0, 1'b1, 8'h9C, "R3");

    // B source sweep: R2 codes, R3 byte extension
    for (int c = 0; c < 16; c++)
      for (int x = 0; x < 2; x++)
        step(4'(c), x[0], PASS_B, 9'h002, 1'b0, 32'h0, 1'b0, 8'h0, (c == 2) ? "R3" : "R2");
    step(4'd0, 1'b0, 8'h00, 9'h0, 1'b0, 32'h0, 1'b1, 8'h41, "R3");
    step(4'd2, 1'b1, PASS_B, 9'h002, 1'b0, 32'h0, 1'b0, 8'h0, "R3");

    // R9: hold loaded from a B source, then read back as left operand
    step(4'd3, 1'b0, PASS_B, 9'h001, 1'b0, 32'h0, 1'b0, 8'h0, "R9");
    readreg(0, "R9");

    // ALU and shifter sweep: R4, R5
    for (int p = 0; p < 4; p++) begin
      load(0, opa[p]);
      load(7, opb[p]);
      for (int ac = 0; ac < 256; ac++)
        step(4'd6, 1'b0, 8'(ac), 9'h002, 1'b0, 32'h0, 1'b0, 8'h0, ac[7] | ac[6] ? "R5" : "R4");
    end

    // C mask sweep: R7
    for (int m = 0; m < 512; m++) begin
      step(4'd0, 1'b0, 8'h00, 9'h0, 1'b1, 32'hA500_0000 | 32'(m * 977), 1'b0, 8'h0, "R10");
      step(4'd0, 1'b0, INC_B, 9'(m), 1'b0, 32'h0, 1'b0, 8'h0, "R7");
      if (m % 37 == 0 || m == 511)
        for (int k = 0; k < 9; k++) readreg(k, "R7");
    end

    // R8: read and write the same register in one cycle
    load(4, 32'h0000_00FF);
    step(4'd3, 1'b0, INC_B, 9'h010, 1'b0, 32'h0, 1'b0, 8'h0, "R8");
    readreg(4, "R8");
    step(4'd1, 1'b0, INC_B, 9'h018, 1'b0, 32'h0, 1'b0, 8'h0, "R8");
    readreg(4, "R8");

    // R11: C write and memory load collide on the data register
    step(4'd3, 1'b0, PASS_B, 9'h004, 1'b1, 32'hDEAD_BEEF, 1'b0, 8'h0, "R11");
    chk("R11", data_out, sh[4]);
    // R10: memory load alone
    step(4'd3, 1'b0, PASS_B, 9'h002, 1'b1, 32'hCAFE_0001, 1'b0, 8'h0, "R10");
    chk("R10", data_out, 32'hCAFE_0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule